// File: doc/BRIEF.md
# Longest Pass Window Center Finder

This block scans a 64-entry pass/fail map of delay taps and picks the middle of the widest window of passing taps. It is meant for the last step of an interface timing sweep. Firmware or a sweep sequencer marks each tested tap, then hands the map to this block together with the first tap to consider and how many taps to consider. The block walks the selected range one tap per clock. When it has finished, it pulses `done` and presents the winning window's width and its middle tap.

A cleared bit marks a passing tap. A set bit marks a failing tap. The reported tap index is absolute within the map. Results stay on the outputs until the next job completes.

Top module: `pass_window_finder`

## Requirements
- R1: A map bit of 0 is a passing tap and a bit of 1 is a failing tap; `run_len` reports the length of the longest unbroken stretch of 0 bits inside the scanned range.
- R2: The scanned range is taps `first_idx` through `first_idx + span - 1`. Bits outside it never join or break a run.
- R3: When several runs share the greatest length, the one starting at the lowest tap index wins. A later run replaces the stored best only when it is strictly longer.
- R4: `center` equals the winning run's first tap index plus `run_len / 2` rounded down. It is an absolute map index, so a scan starting at 32 yields 32 or more.
- R5: When the range holds no passing tap, `run_len` is 0, `found` is 0 and `center` is 0. Otherwise `found` is 1.
- R6: A run that is still open at the last tap of the range is closed there and compared, exactly like a run ended by a failing tap.
- R7: A job with `span` = 0 completes with an empty result (R5), and `done` rises one cycle after the start edge.
- R8: If `first_idx + span` exceeds 64, the range is cut at tap 63.
- R9: `start` is sampled only while idle; `map_in`, `first_idx` and `span` are captured on that edge. For an effective range of N taps, `done` is high in cycle max(N,1) after the capturing edge. A `start` raised while a job runs is ignored and produces no extra `done`.
- R10: `done` is a one-cycle pulse. `run_len`, `center` and `found` change only together with `done` and hold their values in between.
- R11: After reset, `done`, `found`, `run_len` and `center` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job; honoured only when idle |
| map_in | input | 64 | Pass(0)/fail(1) map, bit i is tap i |
| first_idx | input | 6 | First tap of the range |
| span | input | 7 | Number of taps in the range (0 to 64) |
| run_len | output | 7 | Length of the longest passing run |
| center | output | 6 | Absolute middle tap of that run |
| found | output | 1 | At least one passing tap was seen |
| done | output | 1 | One-cycle pulse when results update |

## Verification
Two kinds of internal fault are possible. A stale current-run counter or a wrongly kept best register shows up as a wrong `run_len` or `center` on the very `done` pulse of the affected job. A mistracked remaining-tap counter shows up as `done` arriving in the wrong cycle, or never arriving, so the bench timestamps every pulse against max(N,1).

Tie breaking and the closing of a run at the range boundary have their own maps. In those maps only the faulty behaviour would move the reported window. A busy flag that failed to block a second `start` would cause an unexpected second `done` or corrupted results for the first job.

// File: rtl/pass_window_finder.sv
module pass_window_finder #(
  parameter int MAP_W = 64,
  localparam int IW = $clog2(MAP_W),
  localparam int CW = $clog2(MAP_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [MAP_W-1:0] map_in,
  input  logic [IW-1:0]    first_idx,
  input  logic [CW-1:0]    span,
  output logic [CW-1:0]    run_len,
  output logic [IW-1:0]    center,
  output logic             found,
  output logic             done
);

  logic [MAP_W-1:0] map_q;
  logic             busy;
  logic [IW-1:0]    pos, cur_start, best_start;
  logic [CW-1:0]    rem, cur_len, best_len;

  logic [CW:0]   room;
  logic [CW-1:0] eff;
  assign room = (CW+1)'(MAP_W) - (CW+1)'(first_idx);
  assign eff  = ({1'b0, span} > room) ? room[CW-1:0] : span;

  logic          live, pass, last, better;
  logic [CW-1:0] run_now, fin_len, mid;
  logic [IW-1:0] run_beg, fin_start;

  assign live      = rem != '0;
  assign pass      = live && !map_q[pos];
  assign last      = rem <= CW'(1);
  assign run_now   = pass ? cur_len + CW'(1) : cur_len;
  assign run_beg   = (cur_len == '0) ? pos : cur_start;
  assign better    = (!pass || last) && (run_now > best_len);
  assign fin_len   = better ? run_now : best_len;
  assign fin_start = better ? run_beg : best_start;
  assign mid       = CW'(fin_start) + (fin_len >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q      <= '0;
      busy       <= 1'b0;
      pos        <= '0;
      rem        <= '0;
      cur_len    <= '0;
      cur_start  <= '0;
      best_len   <= '0;
      best_start <= '0;
      run_len    <= '0;
      center     <= '0;
      found      <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          map_q      <= map_in;
          pos        <= first_idx;
          rem        <= eff;
          cur_len    <= '0;
          cur_start  <= '0;
          best_len   <= '0;
          best_start <= '0;
          busy       <= 1'b1;
        end
      end else if (last) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        run_len <= fin_len;
        found   <= fin_len != '0;
        center  <= (fin_len != '0) ? mid[IW-1:0] : '0;
      end else begin
        pos        <= pos + IW'(1);
        rem        <= rem - CW'(1);
        cur_len    <= pass ? run_now : '0;
        cur_start  <= run_beg;
        best_len   <= fin_len;
        best_start <= fin_start;
      end
    end
  end

endmodule

// File: rtl/pass_window_finder_chk.sv
module pass_window_finder_chk #(
  parameter int MAP_W = 64,
  localparam int IW = $clog2(MAP_W),
  localparam int CW = $clog2(MAP_W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] run_len,
  input logic [IW-1:0] center,
  input logic          found,
  input logic          done
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(run_len) && $stable(center) && $stable(found))); // R10

  AST_FOUND_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (found == (run_len != '0))); // R5

  AST_EMPTY_CENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> (center == '0)); // R5

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len <= CW'(MAP_W))); // R1

endmodule

bind pass_window_finder pass_window_finder_chk #(.MAP_W(MAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_len(run_len),
  .center(center), .found(found), .done(done));

// File: tb/sim_pass_window_finder.sv
`timescale 1ns/1ps
module sim_pass_window_finder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] map_in = '1;
  logic [5:0]  first_idx = '0;
  logic [6:0]  span = '0;
  logic [6:0]  run_len;
  logic [5:0]  center;
  logic        found, done;

  always #2.5 clk = ~clk;

  pass_window_finder u0 (.clk(clk), .rst_n(rst_n), .start(start), .map_in(map_in),
    .first_idx(first_idx), .span(span), .run_len(run_len), .center(center),
    .found(found), .done(done));

  typedef struct {
    int    len;
    int    ctr;
    int    fnd;
    int    cyc;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;
  int checks = 0, fails = 0, cyc = 0, done_cnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic void ref_scan(input logic [63:0] m, input int lo, input int sp,
                                   output int len, output int ctr, output int n);
    int hi = lo + sp;
    if (hi > 64) hi = 64;
    n = hi - lo;
    len = 0; ctr = 0;
    for (int s = lo; s < hi; s++) begin
      if (!m[s] && (s == lo || m[s-1])) begin
        int k = 0;
        while (s + k < hi && !m[s+k]) k++;
        if (k > len) begin len = k; ctr = s + k / 2; end
      end
    end
  endfunction

  always @(negedge clk) begin
    if (rst_n && done) begin
      done_cnt++;
      if (q.size() == 0) begin
        check("R9 unexpected done", 1, 0);
      end else begin
        mon_e = q.pop_front();
        check({mon_e.tag, " run_len"}, int'(run_len), mon_e.len);
        check({mon_e.tag, " center"}, int'(center), mon_e.ctr);
        check({mon_e.tag, " found"}, int'(found), mon_e.fnd);
        check({mon_e.tag, " R9 latency"}, cyc, mon_e.cyc);
      end
    end
  end

  task automatic run_job(logic [63:0] m, int lo, int sp, string tag);
    exp_t e;
    int len, ctr, n, target;
    ref_scan(m, lo, sp, len, ctr, n);
    e.len = len; e.ctr = ctr; e.fnd = (len != 0);
    e.cyc = cyc + 1 + ((n < 1) ? 1 : n);
    e.tag = tag;
    q.push_back(e);
    target = done_cnt + 1;
    map_in = m; first_idx = 6'(lo); span = 7'(sp); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (done_cnt == target);
    @(negedge clk);
    check({tag, " R10 pulse"}, int'(done), 0);
  endtask

  function automatic logic [63:0] zeros(logic [63:0] m, int a, int b);
    for (int i = a; i <= b; i++) m[i] = 1'b0;
    return m;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual 1 expected 0");
    finish_run();
  end

  initial begin
    int l0, c0, f0, dc;
    repeat (3) @(negedge clk);
    check("R11 done", int'(done), 0);
    check("R11 found", int'(found), 0);
    check("R11 run_len", int'(run_len), 0);
    check("R11 center", int'(center), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_job('1, 0, 64, "R5 all fail");
    run_job('0, 0, 64, "R1 all pass");
    run_job(zeros(zeros('1, 4, 7), 20, 23), 0, 64, "R3 tie");
    run_job(zeros(zeros('1, 2, 3), 30, 35), 0, 64, "R3 longer later");
    run_job(zeros(zeros('1, 10, 15), 16, 30), 0, 16, "R6 open at end R2");
    run_job(zeros(zeros('1, 0, 20), 40, 44), 32, 32, "R4 upper half R2");
    run_job(zeros('1, 9, 11), 0, 64, "R4 odd floor");
    run_job('0, 5, 0, "R7 empty span");
    run_job(zeros('1, 60, 63), 60, 20, "R8 clipped");

    l0 = run_len; c0 = center; f0 = found;
    repeat (5) @(negedge clk);
    check("R10 hold run_len", int'(run_len), l0);
    check("R10 hold center", int'(center), c0);
    check("R10 hold found", int'(found), f0);

    begin
      exp_t e;
      int len, ctr, n;
      logic [63:0] m = zeros('1, 8, 12);
      ref_scan(m, 0, 64, len, ctr, n);
      e.len = len; e.ctr = ctr; e.fnd = 1; e.cyc = cyc + 1 + n; e.tag = "R9 busy";
      q.push_back(e);
      dc = done_cnt;
      map_in = m; first_idx = 0; span = 64; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      map_in = '0; first_idx = 6'd1; span = 7'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait (done_cnt == dc + 1);
      repeat (10) @(negedge clk);
      check("R9 single done", done_cnt, dc + 1);
    end

    check("R9 queue empty", q.size(), 0);
    finish_run();
  end
endmodule